// File: doc/BRIEF.md
# Bus Cycle T-State Sequencer

This block is the bus-master end of a multiplexed address/data bus. A client presents a transfer (address, write data, a memory-or-I/O flag and a direction) on a valid/ready request port. The block then runs a bus cycle of fixed phases: an address phase (T1), a strobe phase (T2), an access phase (T3) and a release phase (T4). Between T2 and T3 it inserts wait states for as long as the slave holds `bus_ready` low. Each cycle runs at least four clocks and exactly 4 + N clocks when N wait states are inserted. At a 125 ns clock with two wait states that gives 750 ns.

The block drives the address latch enable, the direction select, the memory/I/O select, the data enable and active-low read and write strobes. The multiplexed bus is split into an output word `ad_o`, its enable `ad_oe` and an input word `ad_i`, so that a pad ring or an upper level can form the tri-state pin. For reads, the block captures the low data bits at the end of T3 and returns them with a one-clock acknowledge in T4. Writes are acknowledged in T4 in the same way. When no request is pending the block sits in idle states of one clock each. A request presented during T4 starts the next T1 with no idle clock in between.

Top module: `bus_tstate_seq`

## Requirements
- R1: After reset `rd_n`=1, `wr_n`=1, `addr_le`=0, `data_en`=0, `ad_oe`=0, `dir_tx`=0, `mem_sel`=0, `rsp_valid`=0, `rsp_rdata`=0, and `req_ready`=1.
- R2: In T1 (the clock after a request is accepted) `addr_le`=1 for that single clock, `ad_oe`=1 and `ad_o` equals the request address. From T1 through T4, `dir_tx` equals the write flag (1 = write) and `mem_sel` equals the inverse of the I/O flag (1 = memory).
- R3: From T2 through T3, including any wait states, `data_en`=1 and exactly one strobe is low: `rd_n` for a read, `wr_n` for a write. For a write `ad_oe`=1 and `ad_o` carries the write data, zero-extended to the address width.
- R4: `bus_ready` is sampled at the end of T2 and at the end of every wait state. While it is low another wait state follows, with the strobe held. `bus_ready` is ignored in T3.
- R5: For a read, `ad_i` is captured at the end of T3 (not earlier) and appears on `rsp_rdata` during T4 together with a one-clock `rsp_valid` pulse. A write also pulses `rsp_valid` in T4 but leaves `rsp_rdata` unchanged.
- R6: In T4 both strobes are high and `data_en`=0 and `ad_oe`=0.
- R7: A cycle with N wait states spans exactly 4 + N clocks, from T1 to T4 inclusive.
- R8: During a read the bus is not driven from T2 onward: `ad_oe`=0 whenever `data_en`=1 and `dir_tx`=0.
- R9: `req_ready` is 1 only in idle and in T4, and 0 from T1 through T3. A request accepted in T4 is followed directly by T1.
- R10: With no request pending the block stays idle, one clock per idle state, with `addr_le`=0, both strobes high and the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-clock acknowledge in T4 |
| rsp_rdata | output | DW | Captured read data |
| addr_le | output | 1 | Address latch enable, high in T1 |
| dir_tx | output | 1 | Data direction, 1 = master drives data |
| mem_sel | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| data_en | output | 1 | Data buffer enable, T2 to T3 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_ready | input | 1 | Slave ready, low inserts wait states |
| ad_o | output | AW | Multiplexed bus output word |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_i | input | DW | Multiplexed bus data input |

## Verification
The bench drives the read value onto `ad_i` only during T3 and keeps its complement there in T2 and the wait states. A design that captures one clock early or late therefore returns the complement. `bus_ready` is high in exactly one strobe-phase clock and low in T3. A design that samples ready in the wrong state either skips wait states or hangs in them, and the total cycle length, counted from the strobes seen at the pins, no longer equals 4 + N. Back-to-back requests check that T4 hands over straight to T1 without a spare idle clock. A write between two reads checks that a write acknowledge does not disturb the read data.

// File: rtl/bts_pkg.sv
`timescale 1ns/1ps
package bts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } tstate_e;

  // clocks in a bus cycle for a given number of wait states
  function automatic int unsigned cycle_clocks(int unsigned nwait);
    return 32'd4 + nwait;
  endfunction

  // states in which a strobe and the data enable are active
  function automatic logic strobe_phase(tstate_e s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction

  // states in which a new request may be taken
  function automatic logic may_accept(tstate_e s);
    return (s == ST_IDLE) || (s == ST_T4);
  endfunction

endpackage

// File: rtl/bts_fsm.sv
`timescale 1ns/1ps
module bts_fsm
  import bts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    bus_ready,
  output tstate_e st
);

  tstate_e st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_T1;
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = bus_ready ? ST_T3 : ST_TW;
      ST_TW:   st_nx = bus_ready ? ST_T3 : ST_TW;
      ST_T3:   st_nx = ST_T4;
      ST_T4:   st_nx = start ? ST_T1 : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // cycle length bookkeeping for the assertions
  logic [CNT_W-1:0] len_cnt;
  logic [CNT_W-1:0] wait_cnt;
  wire  ev_enter_t1 = (st_nx == ST_T1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_cnt  <= '0;
      wait_cnt <= '0;
    end else if (ev_enter_t1) begin
      len_cnt  <= CNT_W'(1);
      wait_cnt <= '0;
    end else if (st != ST_IDLE) begin
      len_cnt  <= len_cnt + 1'b1;
      if (st == ST_TW) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T2 || st == ST_TW) && !bus_ready) |=> (st == ST_TW)); // R4
  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T4) |-> (len_cnt == CNT_W'(cycle_clocks(32'(wait_cnt))))); // R7
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start) |=> (st == ST_IDLE)); // R10

endmodule

// File: rtl/bts_drive.sv
`timescale 1ns/1ps
module bts_drive
  import bts_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tstate_e       st,
  input  logic          accept,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          addr_le,
  output logic          dir_tx,
  output logic          mem_sel,
  output logic          data_en,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe
);

  logic          lat_wr;
  logic          lat_io;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_wr    <= 1'b0;
      lat_io    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_wr    <= req_write;
      lat_io    <= req_io;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
    end
  end

  wire busy   = (st != ST_IDLE);
  wire strobe = strobe_phase(st);

  always_comb begin
    addr_le = (st == ST_T1);
    dir_tx  = busy & lat_wr;
    mem_sel = busy & ~lat_io;
    data_en = strobe;
    rd_n    = ~(strobe & ~lat_wr);
    wr_n    = ~(strobe & lat_wr);
    ad_oe   = (st == ST_T1) | (strobe & lat_wr);
    if (st == ST_T1)           ad_o = lat_addr;
    else if (strobe && lat_wr) ad_o = AW'(lat_wdata);
    else                       ad_o = '0;
  end

  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_le |=> !addr_le); // R2
  AST_T4_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && !strobe) |-> (rd_n && wr_n && !ad_oe)); // R6

endmodule

// File: rtl/bts_capture.sv
`timescale 1ns/1ps
module bts_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          is_read,
  input  logic [DW-1:0] ad_i,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture && is_read) rsp_rdata <= ad_i;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && is_read) |=> $stable(rsp_rdata)); // R5

endmodule

// File: rtl/bus_tstate_seq.sv
`timescale 1ns/1ps
module bus_tstate_seq
  import bts_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          addr_le,
  output logic          dir_tx,
  output logic          mem_sel,
  output logic          data_en,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          bus_ready,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i
);

  tstate_e st;

  // named internal events
  wire ev_accept  = req_valid & may_accept(st);
  wire ev_capture = (st == ST_T3);

  assign req_ready = may_accept(st);

  bts_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_accept),
    .bus_ready (bus_ready),
    .st        (st)
  );

  bts_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .accept    (ev_accept),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .addr_le   (addr_le),
    .dir_tx    (dir_tx),
    .mem_sel   (mem_sel),
    .data_en   (data_en),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe)
  );

  bts_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (ev_capture),
    .is_read   (~dir_tx),
    .ad_i      (ad_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3
  AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> addr_le); // R9
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !dir_tx) |-> !ad_oe); // R8

endmodule

// File: tb/test_bus_tstate_seq.sv
`timescale 1ns/1ps
module test_bus_tstate_seq;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          addr_le, dir_tx, mem_sel, data_en, rd_n, wr_n;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] ad_o;
  logic          ad_oe;
  logic [DW-1:0] ad_i = '0;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] exp_rdata = '0;

  bus_tstate_seq #(.AW(AW), .DW(DW)) i_bus_tstate_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .addr_le(addr_le), .dir_tx(dir_tx), .mem_sel(mem_sel), .data_en(data_en),
    .rd_n(rd_n), .wr_n(wr_n), .bus_ready(bus_ready), .ad_o(ad_o),
    .ad_oe(ad_oe), .ad_i(ad_i)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_n && wr_n, "R1", "strobes", {30'd0, rd_n, wr_n}, 32'h3);
    chk(!addr_le && !data_en && !ad_oe, "R1", "ale/den/oe",
        {29'd0, addr_le, data_en, ad_oe}, 32'h0);
    chk(!dir_tx && !mem_sel, "R1", "dir/mem", {30'd0, dir_tx, mem_sel}, 32'h0);
    chk(!rsp_valid && rsp_rdata == '0, "R1", "rsp", {15'd0, rsp_valid, rsp_rdata}, 32'h0);
    chk(req_ready, "R1", "req_ready", {31'd0, req_ready}, 32'h1);
  endtask

  task automatic t_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!addr_le && rd_n && wr_n && !ad_oe && !data_en && req_ready, "R10",
          "idle outputs", {26'd0, addr_le, rd_n, wr_n, ad_oe, data_en, req_ready},
          32'h19);
    end
  endtask

  // Called at a negedge where the block is idle or in T4; returns at the T4 negedge.
  task automatic do_cycle(input bit wr, input bit io, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wdata, input int nwait,
                          input logic [DW-1:0] rdval);
    int c;
    bit strobe_n;
    chk(req_ready, "R9", "ready before accept", {31'd0, req_ready}, 32'h1);
    req_valid = 1'b1; req_write = wr; req_io = io; req_addr = addr; req_wdata = wdata;
    bus_ready = 1'b0; ad_i = ~rdval;
    @(negedge clk); // T1
    chk(addr_le, "R2", "ale in T1", {31'd0, addr_le}, 32'h1);
    chk(ad_oe && ad_o == addr, "R2", "address", ad_o, addr);
    chk(dir_tx == wr && mem_sel == !io, "R2", "dir/mem", {30'd0, dir_tx, mem_sel},
        {30'd0, wr, !io});
    chk(!req_ready, "R9", "busy in T1", {31'd0, req_ready}, 32'h0);
    req_valid = 1'b0;
    c = 0;
    while (c < 64) begin
      @(negedge clk);
      strobe_n = wr ? wr_n : rd_n;
      if (strobe_n) break;
      c++;
      chk(data_en && (wr ? rd_n : wr_n) && !addr_le, "R3", "strobe phase",
          {29'd0, data_en, rd_n, wr_n}, {29'd0, 1'b1, wr, !wr});
      if (wr)
        chk(ad_oe && ad_o == AW'(wdata), "R3", "write data", ad_o, AW'(wdata));
      else
        chk(!ad_oe, "R8", "read bus floats", {31'd0, ad_oe}, 32'h0);
      chk(!req_ready, "R9", "busy in strobe", {31'd0, req_ready}, 32'h0);
      chk(dir_tx == wr && mem_sel == !io, "R2", "dir/mem held",
          {30'd0, dir_tx, mem_sel}, {30'd0, wr, !io});
      bus_ready = (c == nwait + 1);
      ad_i = (c == nwait + 2) ? rdval : ~rdval;
    end
    // now in T4
    chk(c + 2 == 4 + nwait, "R7", "cycle clocks", c + 2, 4 + nwait);
    chk(c == 2 + nwait, "R4", "strobe clocks", c, 2 + nwait);
    chk(rd_n && wr_n && !data_en && !ad_oe, "R6", "T4 release",
        {29'd0, rd_n & wr_n, data_en, ad_oe}, 32'h4);
    if (!wr) exp_rdata = rdval;
    chk(rsp_valid, "R5", "ack in T4", {31'd0, rsp_valid}, 32'h1);
    chk(rsp_rdata == exp_rdata, "R5", "read data", rsp_rdata, exp_rdata);
    chk(req_ready, "R9", "ready in T4", {31'd0, req_ready}, 32'h1);
    ad_i = 16'hdead;
  endtask

  task automatic t_after_ack();
    @(negedge clk);
    chk(!rsp_valid, "R5", "ack single clock", {31'd0, rsp_valid}, 32'h0);
    chk(rsp_rdata == exp_rdata, "R5", "rdata held", rsp_rdata, exp_rdata);
  endtask

  task automatic t_back_to_back();
    do_cycle(1'b1, 1'b0, 20'h0_1234, 16'hbeef, 0, 16'h0);
    do_cycle(1'b0, 1'b1, 20'h0_0060, 16'h0, 1, 16'h5a3c); // R9 starts from T4
    t_after_ack();
  endtask

  initial begin
    t_reset();
    t_idle(3);
    do_cycle(1'b0, 1'b0, 20'hA_5F31, 16'h0, 0, 16'h1357);
    t_after_ack();
    t_idle(1);
    do_cycle(1'b1, 1'b1, 20'h0_03F8, 16'hC0DE, 2, 16'h0);
    t_after_ack();
    do_cycle(1'b0, 1'b0, 20'hF_FFFE, 16'h0, 3, 16'h8001);
    t_after_ack();
    t_back_to_back();
    do_cycle(1'b1, 1'b0, 20'h1_0000, 16'h7777, 5, 16'h0);
    t_after_ack();
    t_idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule